// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides, for each received Ethernet destination address, whether the frame is kept or dropped. The six address bytes arrive one per cycle. The first byte comes with a start strobe. While the bytes arrive, a running CRC-32 is built over them. After the sixth byte, the upper bits of the reflected and complemented CRC index a programmable bit table. One cycle later the block gives a single-cycle decision.

Software programs the block through a small register port. The port holds a filter control word, one exact-match unicast address, and the hash table words. It also exposes a read-only feature word that reports the table size.

The table size `TBL_BITS` is a parameter and may be 64, 128 or 256 bits. The hash index width follows from it and is 6, 7 or 8 bits.

Top module: `mc_hash_filter`

## Requirements
- R1: After reset, the control word, the unicast address words and every table word read as zero, and `dec_vld_o` is low.
- R2: The hash index is formed in four steps:
  - run a CRC-32 (reflected polynomial 0xEDB88320, all-ones start) over the six address bytes, first byte first and LSB first within each byte;
  - complement the result;
  - bit-reverse it across 32 bits;
  - keep the top log2(`TBL_BITS`) bits.

  Index bits [msb:5] select table word i, and index bits [4:0] select the bit within that word.
- R3: `dec_vld_o` is high for exactly one cycle, in the cycle after the sixth address byte is accepted, and at no other time. `dec_accept_o` is low whenever `dec_vld_o` is low.
- R4: A byte presented with `start_i` high always becomes byte 0 of a new address, discarding any partial address and CRC state. Bytes that arrive after the sixth byte and before the next start are ignored.
- R5: When control bit 0 (promiscuous) is 1, every address is accepted.
- R6: When control bit 4 (pass all multicast) is 1, every multicast address is accepted without consulting the table.
- R7: When control bit 2 (hash multicast) is 1, a multicast address is accepted exactly when its table bit is 1. The broadcast address (all ones) is accepted whenever bit 2 or bit 4 is 1.
- R8: A unicast address is accepted when it equals the programmed unicast address. Byte k of that address sits at bits [8k+7:8k] of {word 0x44[15:0], word 0x40}. A unicast address is also accepted when control bit 10 (hash or perfect) and bit 2 are both 1 and its table bit is 1. Otherwise it is rejected.
- R9: An address is multicast when bit 0 of its first byte is 1. With control bits 0, 2 and 4 all clear, every multicast address is rejected.
- R10: A write to the control word at 0x08 changes only the bits set in `reg_wmask_i`. Only bits 0, 2, 4, 6, 7 and 10 are implemented; the others read as zero. Bits [7:6] (pass control frames) are storage only.
- R11: The read-only feature word at 0x0C returns log2(`TBL_BITS`/32) in bits [25:24] and zero elsewhere. Writes to it have no effect.
- R12: Table word i sits at 0x10 + 4*i. Words with i below `TBL_BITS`/32 are writable under the mask. Words from there up to 0x2C ignore writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Marks the byte on `byte_i` as the first address byte |
| byte_vld_i | input | 1 | `byte_i` holds an address byte this cycle |
| byte_i | input | 8 | Destination address byte |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_wmask_i | input | 32 | Per-bit write mask |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| dec_vld_o | output | 1 | Decision strobe |
| dec_accept_o | output | 1 | Frame accepted, qualified by `dec_vld_o` |

## Verification
The bench builds the block with `TBL_BITS` = 128. This gives a 7-bit index that spans four table words. It also leaves words 4 to 7 unimplemented, so the ignored-write and read-as-zero behaviour of R12 can be observed, and the feature code reads as 2 rather than a trivial value. The word-select bits above bit 5 are exercised with random tables and addresses, and hash-hit decisions land in several different words.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam logic [7:0] CTRL_OFF = 8'h08;
  localparam logic [7:0] FEAT_OFF = 8'h0C;
  localparam int unsigned TBL_OFF = 'h10;
  localparam int unsigned TBL_MAX_WORDS = 8;
  localparam logic [7:0] UCL_OFF = 8'h40;
  localparam logic [7:0] UCH_OFF = 8'h44;

  localparam int unsigned PROM_BIT = 0;
  localparam int unsigned HMC_BIT  = 2;
  localparam int unsigned PM_BIT   = 4;
  localparam int unsigned HPF_BIT  = 10;
  localparam logic [31:0] CTRL_IMPL = 32'h0000_04D5;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

  typedef struct packed {
    logic prom;
    logic pm;
    logic hmc;
    logic hpf;
  } filt_mode_t;

  function automatic logic [31:0] crc_step_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ d[k]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/mhf_crc_acc.sv
module mhf_crc_acc
  import mhf_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             vld_i,
  input  logic [7:0]       byte_i,
  output logic             done_o,
  output logic [47:0]      addr_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned ADDR_BYTES = 6;

  logic [31:0] crc_q;
  logic [2:0]  cnt_q;
  logic [47:0] addr_q;
  logic        done_q;
  logic        take_next;

  // cnt_q = 0: idle, 1..5: bytes received so far
  assign take_next = vld_i && !start_i && (cnt_q != 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q  <= '1;
      cnt_q  <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= take_next && (cnt_q == 3'(ADDR_BYTES - 1));
      if (vld_i && start_i) begin
        crc_q        <= crc_step_byte('1, byte_i);
        addr_q[7:0]  <= byte_i;
        cnt_q        <= 3'd1;
      end else if (take_next) begin
        crc_q                 <= crc_step_byte(crc_q, byte_i);
        addr_q[cnt_q*8 +: 8]  <= byte_i;
        cnt_q                 <= (cnt_q == 3'(ADDR_BYTES - 1)) ? 3'd0 : cnt_q + 3'd1;
      end
    end
  end

  logic [31:0] rev;
  always_comb begin
    for (int b = 0; b < 32; b++) rev[b] = ~crc_q[31-b];
  end

  assign idx_o  = rev[31 -: IDX_W];
  assign addr_o = addr_q;
  assign done_o = done_q;
endmodule

// File: rtl/mhf_regs.sv
module mhf_regs
  import mhf_pkg::*;
#(
  parameter int unsigned TBL_BITS = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [7:0]          addr_i,
  input  logic [31:0]         wdata_i,
  input  logic [31:0]         wmask_i,
  output logic [31:0]         rdata_o,
  output logic [31:0]         ctrl_o,
  output logic [TBL_BITS-1:0] table_o,
  output logic [47:0]         uc_addr_o
);
  localparam int unsigned NWORDS = TBL_BITS / 32;
  localparam int unsigned IDX_W  = $clog2(TBL_BITS);
  localparam logic [1:0]  SZ_CODE = 2'(IDX_W - 5);

  logic [31:0] ctrl_q, ucl_q;
  logic [15:0] uch_q;
  logic [31:0] tbl_q [NWORDS];

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [31:0] m);
    return (old & ~m) | (d & m);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ucl_q  <= '0;
      uch_q  <= '0;
    end else if (we_i) begin
      if (addr_i == CTRL_OFF) ctrl_q <= merge(ctrl_q, wdata_i, wmask_i) & CTRL_IMPL;
      if (addr_i == UCL_OFF)  ucl_q  <= merge(ucl_q, wdata_i, wmask_i);
      if (addr_i == UCH_OFF)  uch_q  <= (uch_q & ~wmask_i[15:0]) | (wdata_i[15:0] & wmask_i[15:0]);
    end
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    localparam logic [7:0] WADDR = 8'(TBL_OFF + 4 * i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       tbl_q[i] <= '0;
      else if (we_i && addr_i == WADDR)  tbl_q[i] <= merge(tbl_q[i], wdata_i, wmask_i);
    end
    assign table_o[i*32 +: 32] = tbl_q[i];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_OFF) rdata_o = ctrl_q;
    if (addr_i == FEAT_OFF) rdata_o = {6'b0, SZ_CODE, 24'b0};
    if (addr_i == UCL_OFF)  rdata_o = ucl_q;
    if (addr_i == UCH_OFF)  rdata_o = {16'b0, uch_q};
    for (int i = 0; i < NWORDS; i++) begin
      if (addr_i == 8'(TBL_OFF + 4 * i)) rdata_o = tbl_q[i];
    end
  end

  assign ctrl_o    = ctrl_q;
  assign uc_addr_o = {uch_q, ucl_q};
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide
  import mhf_pkg::*;
#(
  parameter int unsigned TBL_BITS = 128,
  localparam int unsigned IDX_W   = $clog2(TBL_BITS)
) (
  input  filt_mode_t          mode_i,
  input  logic [47:0]         addr_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [TBL_BITS-1:0] table_i,
  input  logic [47:0]         uc_addr_i,
  output logic                accept_o
);
  logic is_mc, is_bc, hit, uc_eq;

  assign is_mc = addr_i[0];
  assign is_bc = &addr_i;
  assign hit   = table_i[idx_i];
  assign uc_eq = (addr_i == uc_addr_i);

  always_comb begin
    if (mode_i.prom)                        accept_o = 1'b1;
    else if (is_mc) begin
      if (is_bc && (mode_i.pm || mode_i.hmc)) accept_o = 1'b1;
      else if (mode_i.pm)                   accept_o = 1'b1;
      else if (mode_i.hmc)                  accept_o = hit;
      else                                  accept_o = 1'b0;
    end else
      accept_o = uc_eq || (mode_i.hpf && mode_i.hmc && hit);
  end
endmodule

// File: rtl/mc_hash_filter.sv
module mc_hash_filter
  import mhf_pkg::*;
#(
  parameter int unsigned TBL_BITS = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  input  logic [31:0] reg_wmask_i,
  output logic [31:0] reg_rdata_o,
  output logic        dec_vld_o,
  output logic        dec_accept_o
);
  localparam int unsigned IDX_W = $clog2(TBL_BITS);

  logic [31:0]         ctrl_w;
  logic [TBL_BITS-1:0] table_w;
  logic [47:0]         uc_w, addr_w;
  logic [IDX_W-1:0]    idx_w;
  logic                done_w, acc_w;
  filt_mode_t          mode_w;

  assign mode_w = '{prom: ctrl_w[PROM_BIT], pm: ctrl_w[PM_BIT],
                    hmc: ctrl_w[HMC_BIT], hpf: ctrl_w[HPF_BIT]};

  mhf_regs #(.TBL_BITS(TBL_BITS)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .wmask_i(reg_wmask_i), .rdata_o(reg_rdata_o),
    .ctrl_o(ctrl_w), .table_o(table_w), .uc_addr_o(uc_w)
  );

  mhf_crc_acc #(.IDX_W(IDX_W)) i_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .vld_i(byte_vld_i),
    .byte_i(byte_i), .done_o(done_w), .addr_o(addr_w), .idx_o(idx_w)
  );

  mhf_decide #(.TBL_BITS(TBL_BITS)) i_dec (
    .mode_i(mode_w), .addr_i(addr_w), .idx_i(idx_w), .table_i(table_w),
    .uc_addr_i(uc_w), .accept_o(acc_w)
  );

  assign dec_vld_o    = done_w;
  assign dec_accept_o = done_w & acc_w;
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
  parameter int unsigned TBL_BITS = 128
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        byte_vld_i,
  input logic        reg_we_i,
  input logic [7:0]  reg_addr_i,
  input logic [31:0] reg_rdata_o,
  input logic        dec_vld_o,
  input logic        dec_accept_o,
  input logic [31:0] ctrl_w
);
  localparam int unsigned NWORDS  = TBL_BITS / 32;
  localparam logic [1:0]  SZ_CODE = 2'($clog2(TBL_BITS) - 5);
  localparam logic [8:0]  FREE_LO = 9'('h10 + 4 * NWORDS);

  logic [2:0] seen_q;
  logic       sixth;
  assign sixth = byte_vld_i && !start_i && (seen_q == 3'd5);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     seen_q <= '0;
    else if (byte_vld_i && start_i)  seen_q <= 3'd1;
    else if (byte_vld_i && seen_q != 3'd0)
      seen_q <= (seen_q == 3'd5) ? 3'd0 : seen_q + 3'd1;
  end

  assert_vld_after_sixth_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sixth |=> dec_vld_o);
  assert_no_spurious_vld_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sixth |=> !dec_vld_o);
  assert_accept_qualified_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_accept_o |-> dec_vld_o);
  assert_prom_accepts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_vld_o && ctrl_w[0]) |-> dec_accept_o);
  assert_ctrl_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == 8'h08) |=> $stable(ctrl_w));
  assert_feature_word_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 8'h0C) |-> (reg_rdata_o == {6'b0, SZ_CODE, 24'b0}));
  assert_free_word_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, reg_addr_i} >= FREE_LO && reg_addr_i <= 8'h2C) |-> (reg_rdata_o == '0));
endmodule

bind mc_hash_filter mhf_checker #(.TBL_BITS(TBL_BITS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .byte_vld_i(byte_vld_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .dec_vld_o(dec_vld_o), .dec_accept_o(dec_accept_o), .ctrl_w(ctrl_w)
);

// File: tb/test_mc_hash_filter.sv
module test_mc_hash_filter;
  localparam int TBL_BITS = 128;
  localparam int IW = 7;
  localparam int NW = TBL_BITS / 32;

  logic clk = 0, rst_n = 0;
  logic start = 0, bvld = 0;
  logic [7:0] bdata = 0;
  logic we = 0;
  logic [7:0] raddr = 0;
  logic [31:0] wdata = 0, wmask = 0, rdata;
  logic dvld, dacc;

  always #5 clk = ~clk;

  mc_hash_filter #(.TBL_BITS(TBL_BITS)) i_mc_hash_filter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_vld_i(bvld), .byte_i(bdata),
    .reg_we_i(we), .reg_addr_i(raddr), .reg_wdata_i(wdata), .reg_wmask_i(wmask),
    .reg_rdata_o(rdata), .dec_vld_o(dvld), .dec_accept_o(dacc));

  int checks = 0, fails = 0;
  string tag = "R3";

  // model state
  logic [31:0] m_ctrl = 0, m_ucl = 0, m_uch = 0;
  logic [31:0] m_tbl [8];
  logic [7:0]  q [$];
  bit          active = 0;
  bit          exp_vld = 0, exp_acc = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp, $time);
    end
  endtask

  // MSB-first CRC with bits fed LSB first; top IW bits of its complement form the index
  function automatic int hash_of(logic [7:0] a [6]);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++)
      for (int k = 0; k < 8; k++) begin
        bit fb = c[31] ^ a[i][k];
        c = c << 1;
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    c = ~c;
    return int'(c >> (32 - IW));
  endfunction

  function automatic bit model_accept(logic [7:0] a [6]);
    bit mc = a[0][0];
    bit bc = 1;
    bit ue = 1;
    int h = hash_of(a);
    bit hit = m_tbl[h / 32][h % 32];
    for (int i = 0; i < 6; i++) if (a[i] != 8'hFF) bc = 0;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] u = (i < 4) ? m_ucl[8*i +: 8] : m_uch[8*(i-4) +: 8];
      if (u != a[i]) ue = 0;
    end
    if (m_ctrl[0]) return 1;
    if (mc) begin
      if (bc && (m_ctrl[4] || m_ctrl[2])) return 1;
      if (m_ctrl[4]) return 1;
      if (m_ctrl[2]) return hit;
      return 0;
    end
    return ue || (m_ctrl[10] && m_ctrl[2] && hit);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_vld = 0; active = 0; q = {};
    end else begin
      exp_vld = 0;
      if (bvld) begin
        if (start) begin q = {bdata}; active = 1; end
        else if (active) q.push_back(bdata);
        if (active && q.size() == 6) begin
          logic [7:0] a [6];
          for (int i = 0; i < 6; i++) a[i] = q[i];
          exp_vld = 1; exp_acc = model_accept(a); active = 0;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R3", {31'b0, dvld}, {31'b0, exp_vld});
    if (exp_vld) chk(tag, {31'b0, dacc}, {31'b0, exp_acc});
    else if (dacc) chk("R3", {31'b0, dacc}, 32'd0);
  end

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [31:0] m);
    @(negedge clk);
    we = 1; raddr = a; wdata = d; wmask = m;
    @(negedge clk);
    we = 0;
    if (a == 8'h08) m_ctrl = ((m_ctrl & ~m) | (d & m)) & 32'h4D5;
    if (a == 8'h40) m_ucl = (m_ucl & ~m) | (d & m);
    if (a == 8'h44) m_uch = ((m_uch & ~m) | (d & m)) & 32'hFFFF;
    for (int i = 0; i < NW; i++)
      if (a == 8'(16 + 4*i)) m_tbl[i] = (m_tbl[i] & ~m) | (d & m);
  endtask

  task automatic rd(string r, logic [7:0] a, logic [31:0] exp);
    raddr = a; #1;
    chk(r, rdata, exp);
  endtask

  task automatic send(logic [47:0] a);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      bvld = 1; start = (i == 0); bdata = a[8*i +: 8];
    end
    @(negedge clk);
    bvld = 0; start = 0;
    repeat (2) @(negedge clk);
  endtask

  function automatic int idx_of(logic [47:0] a);
    logic [7:0] b [6];
    for (int i = 0; i < 6; i++) b[i] = a[8*i +: 8];
    return hash_of(b);
  endfunction

  initial begin
    logic [47:0] mc_a, mc_b, uc_a;
    int h;
    for (int i = 0; i < 8; i++) m_tbl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd("R1", 8'h08, 0); rd("R1", 8'h40, 0); rd("R1", 8'h44, 0);
    for (int i = 0; i < NW; i++) rd("R1", 8'(16 + 4*i), 0);
    chk("R1", {31'b0, dvld}, 0);
    // R11 feature word, write ignored
    rd("R11", 8'h0C, 32'h0200_0000);
    wr(8'h0C, '1, '1);
    rd("R11", 8'h0C, 32'h0200_0000);

    mc_a = 48'h01_00_5E_00_00_01; // byte0 = 0x01 (multicast)
    mc_b = 48'h33_22_11_00_5E_01;
    uc_a = 48'h55_44_33_22_11_02;
    // R9 no filter flags
    tag = "R9"; send(mc_a); send(uc_a);
    // R8 exact unicast
    tag = "R8";
    wr(8'h40, uc_a[31:0], '1); wr(8'h44, {16'b0, uc_a[47:32]}, '1);
    rd("R8", 8'h44, {16'b0, uc_a[47:32]});
    send(uc_a); send(uc_a ^ 48'h0100_0000_0000);
    // R7 / R2 hash multicast
    tag = "R7"; wr(8'h08, 32'h4, 32'h4);
    send(mc_a);
    h = idx_of(mc_a);
    tag = "R2"; wr(8'(16 + 4*(h/32)), 32'(1) << (h % 32), 32'(1) << (h % 32));
    send(mc_a); send(mc_b);
    tag = "R7"; send('1);
    // R8 hash-or-perfect on unicast
    tag = "R8"; h = idx_of(uc_a ^ 48'h10);
    wr(8'(16 + 4*(h/32)), 32'(1) << (h % 32), 32'(1) << (h % 32));
    send(uc_a ^ 48'h10);
    wr(8'h08, 32'h400, 32'h400);
    send(uc_a ^ 48'h10);
    // R6 pass all multicast
    tag = "R6"; wr(8'h08, 32'h10, 32'h14);
    send(mc_b); send('1); send(uc_a ^ 48'h20);
    // R5 promiscuous
    tag = "R5"; wr(8'h08, 32'h1, 32'h1);
    send(uc_a ^ 48'h40); send(mc_b);
    // R10 masked control write
    wr(8'h08, '1, 32'h40);
    rd("R10", 8'h08, m_ctrl);
    wr(8'h08, '1, 32'hFFFF_F800);
    rd("R10", 8'h08, m_ctrl);
    chk("R10", m_ctrl, 32'h451);
    // R12 unimplemented table words
    for (int i = NW; i < 8; i++) begin
      wr(8'(16 + 4*i), '1, '1);
      rd("R12", 8'(16 + 4*i), 0);
    end
    wr(8'h1C, 32'hA5A5_0000, 32'hFFFF_0000);
    rd("R12", 8'h1C, m_tbl[3]);
    // R4 restart mid-address and ignored trailing bytes
    tag = "R4"; wr(8'h08, 32'h4, '1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); bvld = 1; start = (i == 0); bdata = 8'hC3;
    end
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); bvld = 1; start = (i == 0); bdata = mc_a[8*(i%6) +: 8];
    end
    @(negedge clk); bvld = 0; start = 0;
    repeat (2) @(negedge clk);
    // R2 random tables, modes and addresses, back-to-back frames
    tag = "R2";
    for (int n = 0; n < 60; n++) begin
      logic [47:0] a;
      for (int i = 0; i < NW; i++) wr(8'(16 + 4*i), $urandom, '1);
      wr(8'h08, (n % 3 == 0) ? 32'h404 : 32'h4, '1);
      a = {$urandom, $urandom} ;
      a[0] = (n % 4 != 0);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); bvld = 1; start = (i == 0); bdata = a[8*i +: 8];
      end
    end
    @(negedge clk); bvld = 0; start = 0;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule